// File: doc/BRIEF.md
# Immediate Extender and Next-PC Unit

This block prepares operands and instruction addresses for a 32-bit single-cycle RISC core. It reads the current instruction word and produces the 32-bit immediate operand for the ALU. The opcode class decides how the 16-bit immediate field is widened. Arithmetic, memory and branch opcodes copy bit 15 into the upper half. Logical opcodes fill the upper half with zeros. Every other opcode yields zero. The extended immediate is a purely combinational function of the instruction word.

The block also holds the program counter and loads a new value on each rising clock edge. By default it advances to the next 4-byte instruction. When the comparator reports a taken branch, it moves by a word-scaled signed offset measured from the following instruction. When a jump is requested, it loads an absolute word index that stays inside the current 256 MB region. Jump has priority over branch. A synchronous active-high reset returns the PC to zero.

Top module: `fetch_addr_unit`

## Requirements
- R1: When `rst` is high at a rising clock edge, `pc` becomes 0x00000000 after that edge, whatever the values of `jump` and `br_taken`.
- R2: When `jump` and `br_taken` are both low, `pc` advances by 4 at each rising edge, modulo 2^32, so 0xFFFFFFFC is followed by 0x00000000.
- R3: When `br_taken` is high and `jump` is low, the next `pc` is pc + 4 + 4 × offset, modulo 2^32. The offset is `instr[15:0]` read as a two's-complement value.
- R4: When `jump` is high, the next `pc` has bits 31:28 equal to bits 31:28 of pc + 4, bits 27:2 equal to `instr[25:0]`, and bits 1:0 equal to zero.
- R5: When `jump` and `br_taken` are high together, the jump target of R4 is loaded and the branch target is not.
- R6: For opcodes 0x08 and 0x09 (the add-immediate forms, opcode in `instr[31:26]`), `ext_imm` is `instr[15:0]` with bit 15 copied into bits 31:16. The output range is 0xFFFF8000 to 0x00007FFF.
- R7: For opcodes 0x0C, 0x0D and 0x0E (the logical forms and, or and xor), `ext_imm` is `instr[15:0]` with bits 31:16 equal to zero. The output range is 0x00000000 to 0x0000FFFF.
- R8: For opcodes 0x23 (load) and 0x2B (store), `ext_imm` is the sign-extended `instr[15:0]`.
- R9: For opcodes 0x04 and 0x05 (the conditional branches), `ext_imm` is the sign-extended `instr[15:0]`.
- R10: For any other opcode, including 0x00 (register form) and 0x02 (jump), `ext_imm` is 0x00000000.
- R11: `pc[1:0]` is zero in every cycle after reset.
- R12: `ext_imm` follows a change of `instr` with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the PC updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 32 | Current instruction word |
| br_taken | input | 1 | Branch condition is true for the current instruction |
| jump | input | 1 | Current instruction is an absolute jump |
| pc | output | 32 | Program counter register |
| ext_imm | output | 32 | Extended immediate for the ALU |

## Verification
The only internal state is the PC register, so a wrong next-PC choice appears on `pc` one edge after the stimulus. Every later address then carries the same error. A wrong extension mode holds no state. It shows on `ext_imm` within the same cycle, but only for opcodes of the affected class, and only for immediates whose bit 15 is set. For that reason the sweep covers both halves of the immediate range for every class. The PC tests drive it across the top of the address space, where wrap-around and the jump's region bits can fail.

// File: rtl/fetch_addr_pkg.sv
package fetch_addr_pkg;

    localparam int ILEN  = 32;
    localparam int OPC_W = 6;
    localparam int IMM_W = 16;
    localparam int JMP_W = 26;
    localparam int ALN_W = 2;

    localparam logic [OPC_W-1:0] OPC_ADDI  = 6'h08;
    localparam logic [OPC_W-1:0] OPC_ADDIU = 6'h09;
    localparam logic [OPC_W-1:0] OPC_ANDI  = 6'h0C;
    localparam logic [OPC_W-1:0] OPC_ORI   = 6'h0D;
    localparam logic [OPC_W-1:0] OPC_XORI  = 6'h0E;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 6'h23;
    localparam logic [OPC_W-1:0] OPC_STORE = 6'h2B;
    localparam logic [OPC_W-1:0] OPC_BEQ   = 6'h04;
    localparam logic [OPC_W-1:0] OPC_BNE   = 6'h05;

    typedef enum logic [1:0] {
        EXT_NONE = 2'd0,
        EXT_SIGN = 2'd1,
        EXT_ZERO = 2'd2
    } ext_mode_e;

    typedef enum logic [1:0] {
        NPC_SEQ    = 2'd0,
        NPC_BRANCH = 2'd1,
        NPC_JUMP   = 2'd2
    } npc_sel_e;

    typedef struct packed {
        logic [OPC_W-1:0] opc;
        logic [ILEN-OPC_W-1:0] body;
    } instr_t;

    function automatic ext_mode_e ext_mode_of(input logic [OPC_W-1:0] opc);
        ext_mode_e m;
        case (opc)
            OPC_ADDI, OPC_ADDIU,
            OPC_LOAD, OPC_STORE,
            OPC_BEQ, OPC_BNE:              m = EXT_SIGN;
            OPC_ANDI, OPC_ORI, OPC_XORI:   m = EXT_ZERO;
            default:                       m = EXT_NONE;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/imm_ext.sv
module imm_ext
    import fetch_addr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [ILEN-1:0] instr,
    output logic [XLEN-1:0] ext_imm
);
    localparam int PAD_W = XLEN - IMM_W;

    instr_t           iw;
    ext_mode_e        mode;
    logic [IMM_W-1:0] field;
    logic [PAD_W-1:0] pad;

    always_comb begin
        iw    = instr_t'(instr);
        mode  = ext_mode_of(iw.opc);
        field = instr[IMM_W-1:0];
        case (mode)
            EXT_SIGN: pad = {PAD_W{field[IMM_W-1]}};
            default:  pad = '0;
        endcase
        if (mode == EXT_NONE) ext_imm = '0;
        else                  ext_imm = {pad, field};
    end
endmodule

// File: rtl/npc_select.sv
module npc_select
    import fetch_addr_pkg::*;
(
    input  logic     jump,
    input  logic     br_taken,
    output npc_sel_e sel
);
    always_comb begin
        if (jump)          sel = NPC_JUMP;
        else if (br_taken) sel = NPC_BRANCH;
        else               sel = NPC_SEQ;
    end
endmodule

// File: rtl/pc_target.sv
module pc_target
    import fetch_addr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] pc,
    input  logic [ILEN-1:0] instr,
    input  npc_sel_e        sel,
    output logic [XLEN-1:0] next_pc
);
    localparam int REG_W  = XLEN - JMP_W - ALN_W;
    localparam int PAD_W  = XLEN - IMM_W - ALN_W;
    localparam logic [XLEN-1:0] STEP = XLEN'(1 << ALN_W);

    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] br_ofs;
    logic [XLEN-1:0] br_pc;
    logic [XLEN-1:0] jmp_pc;

    always_comb begin
        seq_pc = pc + STEP;
        br_ofs = {{PAD_W{instr[IMM_W-1]}}, instr[IMM_W-1:0], {ALN_W{1'b0}}};
        br_pc  = seq_pc + br_ofs;
        jmp_pc = {seq_pc[XLEN-1 -: REG_W], instr[JMP_W-1:0], {ALN_W{1'b0}}};
        case (sel)
            NPC_JUMP:   next_pc = jmp_pc;
            NPC_BRANCH: next_pc = br_pc;
            default:    next_pc = seq_pc;
        endcase
    end
endmodule

// File: rtl/pc_reg.sv
module pc_reg #(
    parameter int XLEN = 32,
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [XLEN-1:0] next_pc,
    output logic [XLEN-1:0] pc
);
    always_ff @(posedge clk) begin
        if (rst) pc <= RESET_PC;
        else     pc <= next_pc;
    end
endmodule

// File: rtl/fetch_addr_unit.sv
module fetch_addr_unit
    import fetch_addr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [31:0]     instr,
    input  logic            br_taken,
    input  logic            jump,
    output logic [XLEN-1:0] pc,
    output logic [XLEN-1:0] ext_imm
);
    npc_sel_e        sel;
    logic [XLEN-1:0] next_pc;

    imm_ext #(.XLEN(XLEN)) u_imm (
        .instr   (instr),
        .ext_imm (ext_imm)
    );

    npc_select u_sel (
        .jump     (jump),
        .br_taken (br_taken),
        .sel      (sel)
    );

    pc_target #(.XLEN(XLEN)) u_tgt (
        .pc      (pc),
        .instr   (instr),
        .sel     (sel),
        .next_pc (next_pc)
    );

    pc_reg #(.XLEN(XLEN), .RESET_PC('0)) u_pc (
        .clk     (clk),
        .rst     (rst),
        .next_pc (next_pc),
        .pc      (pc)
    );
endmodule

// File: rtl/fetch_addr_unit_chk.sv
module fetch_addr_unit_chk
    import fetch_addr_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [31:0] instr,
    input logic        br_taken,
    input logic        jump,
    input logic [31:0] pc,
    input logic [31:0] ext_imm
);
    logic [5:0] opc;
    logic       is_sign, is_zero;
    assign opc     = instr[31:26];
    assign is_sign = (opc == OPC_ADDI) || (opc == OPC_ADDIU) || (opc == OPC_LOAD) ||
                     (opc == OPC_STORE) || (opc == OPC_BEQ) || (opc == OPC_BNE);
    assign is_zero = (opc == OPC_ANDI) || (opc == OPC_ORI) || (opc == OPC_XORI);

    // R1
    reset_pc_chk: assert property (@(posedge clk) rst |=> pc == 32'h0);

    // R2
    seq_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && !jump && !br_taken) |=> pc == $past(pc) + 32'd4);

    // R3
    branch_tgt_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && br_taken && !jump) |=>
        pc == $past(pc) + 32'd4 + {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00});

    // R4 R5
    jump_tgt_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && jump) |=>
        pc[27:0] == {$past(instr[25:0]), 2'b00} &&
        pc[31:28] == ($past(pc) + 32'd4) >> 28);

    // R11
    pc_align_chk: assert property (@(posedge clk) disable iff (rst) pc[1:0] == 2'b00);

    // R6 R8 R9
    sign_ext_chk: assert property (@(posedge clk) disable iff (rst)
        is_sign |-> (ext_imm[15:0] == instr[15:0] && ext_imm[31:16] == {16{instr[15]}}));

    // R7
    zero_ext_chk: assert property (@(posedge clk) disable iff (rst)
        is_zero |-> ext_imm == {16'h0, instr[15:0]});

    // R10
    no_ext_chk: assert property (@(posedge clk) disable iff (rst)
        (!is_sign && !is_zero) |-> ext_imm == 32'h0);
endmodule

bind fetch_addr_unit fetch_addr_unit_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .instr    (instr),
    .br_taken (br_taken),
    .jump     (jump),
    .pc       (pc),
    .ext_imm  (ext_imm)
);

// File: tb/sim_fetch_addr_unit.sv
`timescale 1ns/1ps
module sim_fetch_addr_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr = 32'h0;
    logic        br_taken = 1'b0;
    logic        jump = 1'b0;
    logic [31:0] pc;
    logic [31:0] ext_imm;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] exp_pc;

    always #2 clk = ~clk;

    fetch_addr_unit u0 (
        .clk(clk), .rst(rst), .instr(instr), .br_taken(br_taken),
        .jump(jump), .pc(pc), .ext_imm(ext_imm)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_imm(input logic [5:0] opc, input logic [15:0] imm);
        int v;
        v = int'(imm);
        case (opc)
            6'h08, 6'h09, 6'h23, 6'h2B, 6'h04, 6'h05:
                return (v >= 32768) ? 32'(v - 65536) : 32'(v);
            6'h0C, 6'h0D, 6'h0E: return 32'(v);
            default: return 32'h0;
        endcase
    endfunction

    function automatic string imm_req(input logic [5:0] opc);
        case (opc)
            6'h08, 6'h09: return "R6";
            6'h0C, 6'h0D, 6'h0E: return "R7";
            6'h23, 6'h2B: return "R8";
            6'h04, 6'h05: return "R9";
            default: return "R10";
        endcase
    endfunction

    // one clocked step: inputs set at a falling edge, sampled at the next falling edge
    task automatic step(input string req, input logic [31:0] iw, input logic br, input logic j);
        logic [31:0] seq;
        int off;
        instr = iw; br_taken = br; jump = j;
        seq = exp_pc + 32'd4;
        off = int'(iw[15:0]);
        if (off >= 32768) off = off - 65536;
        if (j)       exp_pc = (seq & 32'hF000_0000) + 32'(int'(iw[25:0]) * 4);
        else if (br) exp_pc = seq + 32'(off * 4);
        else         exp_pc = seq;
        @(posedge clk);
        @(negedge clk);
        chk(req, pc, exp_pc);
        chk("R11", {30'h0, pc[1:0]}, 32'h0);
    endtask

    task automatic do_reset();
        rst = 1'b1; jump = 1'b1; br_taken = 1'b1; instr = 32'h0BFF_FFFF;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0; jump = 1'b0; br_taken = 1'b0;
        exp_pc = 32'h0;
        chk("R1", pc, 32'h0);
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [5:0] opcs [12];
        opcs = '{6'h08, 6'h09, 6'h0C, 6'h0D, 6'h0E, 6'h23, 6'h2B,
                 6'h04, 6'h05, 6'h00, 6'h02, 6'h3F};
        @(negedge clk);
        do_reset();

        // R2 sequential
        for (int i = 0; i < 5; i++) step("R2", 32'h0000_0000, 1'b0, 1'b0);
        // R3 forward and backward branches
        step("R3", {6'h04, 10'h0, 16'h0003}, 1'b1, 1'b0);
        step("R3", {6'h05, 10'h0, 16'hFFFE}, 1'b1, 1'b0);
        step("R3", {6'h04, 10'h0, 16'h7FFF}, 1'b1, 1'b0);
        // R4 jump in low region
        step("R4", {6'h02, 26'h012_3456}, 1'b0, 1'b0 | 1'b1);
        // R5 jump beats branch
        step("R5", {6'h02, 26'h000_0040}, 1'b1, 1'b1);
        // move into the top region and jump there
        do_reset();
        step("R3", {6'h04, 10'h0, 16'h8000}, 1'b1, 1'b0);
        chk("R3", pc, 32'hFFFE_0004);
        step("R4", {6'h02, 26'h3FF_FFFF}, 1'b0, 1'b1);
        chk("R4", pc, 32'hFFFF_FFFC);
        // R2 wrap at the top of the address space
        step("R2", 32'h0, 1'b0, 1'b0);
        chk("R2", pc, 32'h0);
        step("R2", 32'h0, 1'b0, 1'b0);
        // R1 synchronous reset mid-run overrides jump and branch
        step("R4", {6'h02, 26'h155_5555}, 1'b0, 1'b1);
        do_reset();
        step("R2", 32'h0, 1'b0, 1'b0);

        // immediate sweep: R6..R10, combinational (R12)
        foreach (opcs[k]) begin
            for (int v = 0; v < 65536; v += 97) begin
                instr = {opcs[k], 10'h155, 16'(v)};
                #1;
                chk(imm_req(opcs[k]), ext_imm, ref_imm(opcs[k], 16'(v)));
            end
            for (int c = 0; c < 4; c++) begin
                logic [15:0] cv;
                cv = (c == 0) ? 16'h0000 : (c == 1) ? 16'h7FFF : (c == 2) ? 16'h8000 : 16'hFFFF;
                instr = {opcs[k], 10'h2AA, cv};
                #1;
                chk("R12", ext_imm, ref_imm(opcs[k], cv));
            end
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule